// File: doc/BRIEF.md
# Receive Queue with Per-Character Error Tags

This block buffers received characters between a serial receiver and a host. Each character goes in with three error tags: a framing tag, a parity tag and a break tag. They travel through the queue next to the byte. The host sees the byte and tags of the oldest stored character at all times. A read strobe discards that character, and the next one is presented on the following cycle.

Two views of error state are provided. The head tags describe only the character at the front of the queue. The aggregate error flag reports whether any tagged character is still stored anywhere in the queue. A running count of tagged entries drives the aggregate flag, so the flag stays set until the last tagged character has been read out, even when the front entry is clean. A push into a full queue is dropped and raises a sticky overrun flag, which a status read strobe clears.

Top module: `rxq_errtag_fifo`

## Requirements
- R1: After synchronous reset the queue is empty: `empty`=1, `count`=0, `head_tags`=0, `any_err`=0 and `overrun`=0.
- R2: A push (`wr_en`=1 while `count` < 64) stores `wr_data` with `wr_tags`. Tag bit 0 is framing, bit 1 is parity and bit 2 is break. Characters leave in the order they were written. After an edge that leaves the queue non-empty, `head_data` shows the oldest stored byte.
- R3: `head_tags` equals the tags stored with the character at the front of the queue. A pop (`rd_en`=1 while non-empty) moves both `head_data` and `head_tags` to the next entry on the following cycle. Any non-zero `head_tags` implies `any_err`=1.
- R4: While the queue is empty, all three bits of `head_tags` read as zero.
- R5: `any_err` is 1 in the cycle after a push with any non-zero tag bit. It stays 1 while at least one stored entry has a non-zero tag.
- R6: `any_err` returns to 0 in the cycle after the last tagged entry is popped, and is 0 whenever the queue is empty.
- R7: A push and a pop accepted on the same edge leave `count` unchanged. The error tally applies both the increment and the decrement on that edge.
- R8: A push while `count` = 64 is dropped, even when a pop occurs on the same edge. In the cycle after such an attempt, `overrun`=1.
- R9: `overrun` remains 1 until an edge with `stat_rd`=1 and no dropped push. When a dropped push and `stat_rd` fall on the same edge, `overrun` is set.
- R10: A pop while the queue is empty is ignored. Count, contents and flags are unchanged by it.
- R11: `count` equals the number of stored characters and never exceeds 64. `empty` is 1 exactly when `count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push strobe from the receiver |
| wr_data | input | 8 | Received byte |
| wr_tags | input | 3 | Error tags of the byte: bit0 framing, bit1 parity, bit2 break |
| rd_en | input | 1 | Host read strobe, pops the front entry |
| stat_rd | input | 1 | Host status read strobe, clears the overrun flag |
| head_data | output | 8 | Byte at the front of the queue (valid while non-empty) |
| head_tags | output | 3 | Tags of the front entry, zero while empty |
| any_err | output | 1 | Some stored entry carries a non-zero tag |
| empty | output | 1 | Queue holds no characters |
| count | output | 7 | Number of stored characters |
| overrun | output | 1 | Sticky flag: a push was dropped because the queue was full |

## Verification
The assertions check these properties on every cycle:
- the count bound and the tally of tagged entries never exceeding the count;
- the stability of the count on a combined push and pop;
- the dropping of pushes into a full queue;
- the ignoring of pops on an empty queue;
- the persistence and setting of the overrun flag;
- the consistency of the head tags, the empty flag and the aggregate flag with one another.

Only the bench's scenarios can show the following behaviour:
- that bytes and tags come out in write order, paired correctly;
- that the aggregate flag clears on exactly the cycle the last tagged entry leaves while clean entries remain;
- that the first byte written into an empty queue appears at the head one edge later.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int TAG_W = 3;

  // Per-character receive error tags; field order fixes bit positions:
  // bit 2 break, bit 1 parity, bit 0 framing.
  typedef struct packed {
    logic brk;
    logic par;
    logic frm;
  } rx_tag_t;

  function automatic logic tag_any(input rx_tag_t t);
    return t.brk | t.par | t.frm;
  endfunction
endpackage

// File: rtl/rxq_store.sv
// Storage array with one write port and one registered read port.
// The read port tracks the next head address and bypasses a write that
// lands on that address, so the head word is ready the cycle after it.
module rxq_store #(
  parameter int WORD_W = 11,
  parameter int DEPTH  = 64,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                        rdata <= '0;
    else if (we && waddr == raddr)  rdata <= wdata;
    else                            rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxq_ptrs.sv
// Pointer and occupancy control for the receive queue.
module rxq_ptrs #(
  parameter int DEPTH = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          ovf_evt,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_addr_nxt,
  output logic [CW-1:0] count,
  output logic          empty
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] count_nxt;
  logic          full_w;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign full_w      = (count == FULL_CNT);
  assign push_ok     = wr_en && !full_w;
  assign pop_ok      = rd_en && !empty;
  assign ovf_evt     = wr_en && full_w;
  assign rd_addr_nxt = pop_ok ? bump(rd_ptr) : rd_ptr;

  always_comb begin
    count_nxt = count;
    if (push_ok && !pop_ok)      count_nxt = count + 1'b1;
    else if (pop_ok && !push_ok) count_nxt = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      empty  <= 1'b1;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      rd_ptr <= rd_addr_nxt;
      count  <= count_nxt;
      empty  <= (count_nxt == '0);
    end
  end

  // R11
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);
  // R11
  empty_match_chk: assert property (@(posedge clk) disable iff (rst)
    empty == (count == '0));
  // R7
  pushpop_stable_chk: assert property (@(posedge clk) disable iff (rst)
    push_ok && pop_ok |=> $stable(count));
  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && full_w && !rd_en |=> count == FULL_CNT);
  // R10
  pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && empty && !wr_en |=> empty && $stable(wr_ptr));
endmodule

// File: rtl/rxq_errtrk.sv
// Tally of tagged entries held in the queue, plus the sticky overrun flag.
module rxq_errtrk #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_ok,
  input  logic          push_tagged,
  input  logic          pop_ok,
  input  logic          head_tagged,
  input  logic          ovf_evt,
  input  logic          stat_rd,
  input  logic [CW-1:0] count,
  output logic          any_err,
  output logic          overrun
);
  logic [CW-1:0] err_cnt;
  logic [CW-1:0] err_nxt;
  logic          inc, dec;

  assign inc = push_ok && push_tagged;
  assign dec = pop_ok && head_tagged;

  always_comb begin
    err_nxt = err_cnt;
    if (inc && !dec)      err_nxt = err_cnt + 1'b1;
    else if (dec && !inc) err_nxt = err_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_cnt <= '0;
      any_err <= 1'b0;
      overrun <= 1'b0;
    end else begin
      err_cnt <= err_nxt;
      any_err <= (err_nxt != '0);
      if (ovf_evt)      overrun <= 1'b1;
      else if (stat_rd) overrun <= 1'b0;
    end
  end

  // R5
  err_le_count_chk: assert property (@(posedge clk) disable iff (rst)
    err_cnt <= count);
  // R5
  tag_push_flag_chk: assert property (@(posedge clk) disable iff (rst)
    inc |=> any_err);
  // R9
  ovr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    overrun && !stat_rd |=> overrun);
  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> overrun);
endmodule

// File: rtl/rxq_errtag_fifo.sv
module rxq_errtag_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int TW    = rxq_pkg::TAG_W,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int WORD_W = DATA_W + TW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TW-1:0]     wr_tags,
  input  logic              rd_en,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] head_data,
  output logic [TW-1:0]     head_tags,
  output logic              any_err,
  output logic              empty,
  output logic [CW-1:0]     count,
  output logic              overrun
);
  import rxq_pkg::*;

  logic              push_ok, pop_ok, ovf_evt;
  logic [AW-1:0]     wr_ptr, rd_addr_nxt;
  logic [WORD_W-1:0] head_word;
  rx_tag_t           head_tag_s, in_tag_s;

  assign in_tag_s = rx_tag_t'(wr_tags);

  rxq_ptrs #(.DEPTH(DEPTH)) ptrs_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .push_ok     (push_ok),
    .pop_ok      (pop_ok),
    .ovf_evt     (ovf_evt),
    .wr_ptr      (wr_ptr),
    .rd_addr_nxt (rd_addr_nxt),
    .count       (count),
    .empty       (empty)
  );

  rxq_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) store_i (
    .clk   (clk),
    .rst   (rst),
    .we    (push_ok),
    .waddr (wr_ptr),
    .wdata ({wr_tags, wr_data}),
    .raddr (rd_addr_nxt),
    .rdata (head_word)
  );

  assign head_tag_s = rx_tag_t'(head_word[WORD_W-1 -: TW]);
  assign head_data  = head_word[DATA_W-1:0];
  assign head_tags  = empty ? '0 : TW'(head_tag_s);

  rxq_errtrk #(.DEPTH(DEPTH)) errtrk_i (
    .clk         (clk),
    .rst         (rst),
    .push_ok     (push_ok),
    .push_tagged (tag_any(in_tag_s)),
    .pop_ok      (pop_ok),
    .head_tagged (tag_any(head_tag_s)),
    .ovf_evt     (ovf_evt),
    .stat_rd     (stat_rd),
    .count       (count),
    .any_err     (any_err),
    .overrun     (overrun)
  );

  // R3
  head_err_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (head_tags != '0) |-> any_err);
  // R6
  empty_noerr_chk: assert property (@(posedge clk) disable iff (rst)
    empty |-> !any_err);
endmodule

// File: tb/rxq_errtag_fifo_tb.sv
module rxq_errtag_fifo_tb_top;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, stat_rd = 1'b0;
  logic [7:0] wr_data = '0;
  logic [2:0] wr_tags = '0;
  logic [7:0] head_data;
  logic [2:0] head_tags;
  logic       any_err, empty, overrun;
  logic [6:0] count;

  int n_cmp = 0;
  int n_bad = 0;

  logic [10:0] q[$];
  bit          m_ovr = 0;

  always #10 clk = ~clk;

  rxq_errtag_fifo dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_tags(wr_tags),
    .rd_en(rd_en), .stat_rd(stat_rd), .head_data(head_data),
    .head_tags(head_tags), .any_err(any_err), .empty(empty), .count(count),
    .overrun(overrun)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit model_err();
    foreach (q[i]) if (q[i][10:8] != 3'b000) return 1;
    return 0;
  endfunction

  task automatic compare_all();
    chk("R11", "count", int'(count), q.size());
    chk("R11", "empty", int'(empty), (q.size() == 0) ? 1 : 0);
    if (q.size() > 0) begin
      chk("R2", "head_data", int'(head_data), int'(q[0][7:0]));
      chk("R3", "head_tags", int'(head_tags), int'(q[0][10:8]));
    end else begin
      chk("R4", "head_tags_empty", int'(head_tags), 0);
    end
    chk(model_err() ? "R5" : "R6", "any_err", int'(any_err), int'(model_err()));
    chk("R9", "overrun", int'(overrun), int'(m_ovr));
  endtask

  // Called at a falling edge: drive, take the rising edge, update model, compare.
  task automatic step(input bit w, input logic [7:0] d, input logic [2:0] t,
                      input bit r, input bit s);
    bit full_pre, push, pop;
    wr_en = w; wr_data = d; wr_tags = t; rd_en = r; stat_rd = s;
    @(posedge clk);
    full_pre = (q.size() == DEPTH);
    push = w && !full_pre;
    pop  = r && (q.size() > 0);
    if (pop)  void'(q.pop_front());
    if (push) q.push_back({t, d});
    if (w && full_pre) m_ovr = 1;
    else if (s)        m_ovr = 0;
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(); step(0, 8'h00, 3'b000, 0, 0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", "empty", int'(empty), 1);
    chk("R1", "count", int'(count), 0);
    chk("R1", "head_tags", int'(head_tags), 0);
    chk("R1", "any_err", int'(any_err), 0);
    chk("R1", "overrun", int'(overrun), 0);

    // R10: pop on empty is ignored
    step(0, 8'h00, 3'b000, 1, 0);
    chk("R10", "count_after_empty_pop", int'(count), 0);

    // R2 / R4: first write appears at head; tags ordering framing, parity, break
    step(1, 8'hA5, 3'b000, 0, 0);
    step(1, 8'h3C, 3'b001, 0, 0);   // framing
    step(1, 8'h7E, 3'b010, 0, 0);   // parity
    step(1, 8'h11, 3'b000, 0, 0);
    step(1, 8'h42, 3'b100, 0, 0);   // break
    chk("R5", "any_err_set", int'(any_err), 1);
    // R3: pops walk the tags of each front entry
    step(0, 8'h00, 3'b000, 1, 0);
    chk("R3", "head_tags_frm", int'(head_tags), 1);
    step(0, 8'h00, 3'b000, 1, 0);
    step(0, 8'h00, 3'b000, 1, 0);
    chk("R5", "any_err_clean_head", int'(any_err), 1);
    // R6: flag clears only when the last tagged entry leaves
    step(0, 8'h00, 3'b000, 1, 0);
    step(0, 8'h00, 3'b000, 1, 0);
    chk("R6", "any_err_cleared", int'(any_err), 0);
    chk("R4", "head_tags_zero", int'(head_tags), 0);

    // R7: simultaneous push and pop
    step(1, 8'h10, 3'b011, 0, 0);
    step(1, 8'h20, 3'b000, 1, 0);
    chk("R7", "count_pushpop", int'(count), 1);
    step(1, 8'h30, 3'b000, 1, 0);
    chk("R7", "any_err_pushpop", int'(any_err), 0);
    step(0, 8'h00, 3'b000, 1, 0);

    // R8 / R11: fill to the limit, then overflow with and without a pop
    for (int i = 0; i < DEPTH; i++) step(1, 8'(i), 3'(i % 5 == 0 ? 4 : 0), 0, 0);
    chk("R11", "count_full", int'(count), DEPTH);
    step(1, 8'hEE, 3'b111, 0, 0);
    chk("R8", "overrun_set", int'(overrun), 1);
    step(1, 8'hEF, 3'b111, 1, 0);
    chk("R8", "drop_with_pop", int'(count), DEPTH - 1);
    // R9: sticky, set wins over clear, then clear
    idle();
    step(1, 8'hF0, 3'b000, 0, 1);    // fills back to DEPTH, clear strobe
    chk("R9", "cleared", int'(overrun), 0);
    step(1, 8'hF1, 3'b000, 0, 1);    // dropped push with clear strobe
    chk("R9", "set_wins", int'(overrun), 1);
    step(0, 8'h00, 3'b000, 0, 1);
    chk("R9", "clear", int'(overrun), 0);
    for (int i = 0; i < DEPTH + 2; i++) step(0, 8'h00, 3'b000, 1, 0);

    // Mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      int phase;
      bit w, r, s;
      phase = (i / 500) % 4;
      w = ($urandom_range(0, 99) < (phase == 1 ? 80 : (phase == 2 ? 20 : 50)));
      r = ($urandom_range(0, 99) < (phase == 1 ? 20 : (phase == 2 ? 80 : 50)));
      s = ($urandom_range(0, 99) < 5);
      step(w, 8'($urandom), ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000, r, s);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule